// File: doc/BRIEF.md
# Up/Down Pulse Counter with Index Reload

This block keeps a signed position count that two independent pulse lines move: a rising edge on the up line adds one and a rising edge on the down line takes one away. Both lines, and the index line, are assumed to be synchronous to the block clock already. The count wraps modulo 2^WIDTH and is read back as a two's complement value. When a step makes the count reach zero, a fixed-length pulse appears on the terminal-count output. The count then keeps moving in the same direction into negative values until it is reloaded.

A reload writes the programmed preload value back into the count. In the default level mode, the reload happens on every cycle in which the index line is high and the present levels of the up and down lines match a selected pair. In edge mode, the reload happens only on a rising edge of the index line, and the up and down levels are ignored. A typical use is a threshold timer. A gated clock drives the down line, the preload holds the threshold, and the index reloads the count between measurements. The terminal-count pulse then fires when the threshold is crossed.

Top module: `pulse_pair_counter`

## Requirements
- R1: While `rst` is high at a clock edge, `count` takes the value of `preload` and `tc_pulse` is low.
- R2: A rising edge of `inc_in`, with no rising edge of `dec_in` and no reload, raises `count` by one at the next clock edge. A line that stays high, or a falling edge, leaves `count` unchanged.
- R3: A rising edge of `dec_in`, with no rising edge of `inc_in` and no reload, lowers `count` by one.
- R4: Rising edges on both lines in the same cycle cancel, and `count` is unchanged.
- R5: When `edge_reload` is 0, `count` loads `preload` in every cycle in which `idx_in` is high and {`inc_in`,`dec_in`} equals `reload_state`. Bit 1 of `reload_state` is compared with `inc_in` and bit 0 with `dec_in`. With any other level pair, no reload happens.
- R6: A reload takes priority over a rising edge on either line in the same cycle.
- R7: `count` steps below zero into negative two's complement values and wraps modulo 2^WIDTH in both directions.
- R8: When a step by one makes `count` zero, `tc_pulse` is high for exactly TC_LEN cycles, starting in the cycle `count` reads zero. A reload to zero does not raise `tc_pulse`.
- R9: When `edge_reload` is 1, the reload happens only on a rising edge of `idx_in`, whatever the levels of `inc_in` and `dec_in`. Holding `idx_in` high causes no further reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; loads the preload |
| inc_in | input | 1 | Up pulse line; a rising edge adds one |
| dec_in | input | 1 | Down pulse line; a rising edge subtracts one |
| idx_in | input | 1 | Index line that requests a reload |
| preload | input | WIDTH | Initial and reload value |
| reload_state | input | 2 | Up/down level pair that qualifies a level reload |
| edge_reload | input | 1 | 1 selects a reload on the rising edge of the index |
| count | output | WIDTH | Count readback, two's complement |
| tc_pulse | output | 1 | Terminal-count pulse, TC_LEN cycles long |

## Verification
The hardest situation to reach is a reload that falls in the same cycle as a counting edge. Only the up/down levels in that cycle decide whether the reload happens, and a missed reload leaves the count off by one. The stimulus selects `reload_state` = 2'b10 so that the rising edge of `inc_in` itself produces the matching level pair. It also checks the wrap through zero from -1 and from 1, where the terminal-count pulse must start and must last exactly TC_LEN cycles.

// File: rtl/pulse_pair_counter.sv
module pulse_pair_counter #(
  parameter int WIDTH  = 32,
  parameter int TC_LEN = 12,
  localparam int TCW   = $clog2(TC_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_in,
  input  logic             dec_in,
  input  logic             idx_in,
  input  logic [WIDTH-1:0] preload,
  input  logic [1:0]       reload_state,
  input  logic             edge_reload,
  output logic [WIDTH-1:0] count,
  output logic             tc_pulse
);

  logic a_q, b_q, z_q;
  logic [TCW-1:0] tc_cnt;
  logic a_edge, b_edge, z_edge, level_hit, reload, up, down, hit_zero;
  logic [WIDTH-1:0] stepped;

  assign a_edge    = inc_in & ~a_q;
  assign b_edge    = dec_in & ~b_q;
  assign z_edge    = idx_in & ~z_q;
  assign level_hit = idx_in && ({inc_in, dec_in} == reload_state);
  assign reload    = edge_reload ? z_edge : level_hit;
  assign up        = a_edge & ~b_edge;
  assign down      = b_edge & ~a_edge;
  assign stepped   = up ? count + 1'b1 : count - 1'b1;
  assign hit_zero  = !reload && (up || down) && (stepped == '0);
  assign tc_pulse  = (tc_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= 1'b0;
      b_q    <= 1'b0;
      z_q    <= 1'b0;
      count  <= preload;
      tc_cnt <= '0;
    end else begin
      a_q <= inc_in;
      b_q <= dec_in;
      z_q <= idx_in;
      if (reload)
        count <= preload;
      else if (up || down)
        count <= stepped;
      if (hit_zero)
        tc_cnt <= TCW'(TC_LEN);
      else if (tc_pulse)
        tc_cnt <= tc_cnt - 1'b1;
    end
  end

endmodule

// File: rtl/pulse_pair_counter_chk.sv
module pulse_pair_counter_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             inc_in,
  input logic             dec_in,
  input logic             idx_in,
  input logic [WIDTH-1:0] preload,
  input logic [1:0]       reload_state,
  input logic             edge_reload,
  input logic [WIDTH-1:0] count,
  input logic             tc_pulse
);

  logic pa, pb, pz;
  always_ff @(posedge clk) begin
    if (rst) begin
      pa <= 1'b0;
      pb <= 1'b0;
      pz <= 1'b0;
    end else begin
      pa <= inc_in;
      pb <= dec_in;
      pz <= idx_in;
    end
  end

  logic ar, br;
  assign ar = inc_in & ~pa;
  assign br = dec_in & ~pb;

  a_r1_reset_load: assert property (@(posedge clk)
    rst |=> (count == $past(preload)) && !tc_pulse);

  a_r5_level_reload: assert property (@(posedge clk) disable iff (rst)
    (!edge_reload && idx_in && ({inc_in, dec_in} == reload_state)) |=> count == $past(preload));

  a_r4_cancel: assert property (@(posedge clk) disable iff (rst)
    (ar && br && !idx_in) |=> $stable(count));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!ar && !br && !idx_in) |=> $stable(count));

  a_r8_tc_at_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(tc_pulse) |-> count == '0);

  a_r9_edge_hold: assert property (@(posedge clk) disable iff (rst)
    (edge_reload && idx_in && pz && !ar && !br) |=> $stable(count));

endmodule

bind pulse_pair_counter pulse_pair_counter_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/pulse_pair_counter_tb.sv
`timescale 1ns/1ps
module pulse_pair_counter_tb;
  localparam int W = 32;
  localparam int TCL = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inc_in = 1'b0, dec_in = 1'b0, idx_in = 1'b0, edge_reload = 1'b0;
  logic [W-1:0] preload = 32'd5;
  logic [1:0] reload_state = 2'b00;
  logic [W-1:0] count;
  logic tc_pulse;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pulse_pair_counter #(.WIDTH(W), .TC_LEN(TCL)) u_dut (
    .clk(clk), .rst(rst), .inc_in(inc_in), .dec_in(dec_in), .idx_in(idx_in),
    .preload(preload), .reload_state(reload_state), .edge_reload(edge_reload),
    .count(count), .tc_pulse(tc_pulse));

  // {inc, dec, idx, expected count}; level mode, reload_state 00, preload 5
  localparam logic [34:0] VEC [11] = '{
    {3'b100, 32'd6},  // R2 rise
    {3'b100, 32'd6},  // R2 held high
    {3'b000, 32'd6},  // R2 fall
    {3'b100, 32'd7},  // R2
    {3'b010, 32'd6},  // R3
    {3'b000, 32'd6},  // R3 fall
    {3'b110, 32'd6},  // R4 cancel
    {3'b000, 32'd6},  // R4
    {3'b001, 32'd5},  // R5 match 00
    {3'b101, 32'd6},  // R5 mismatch, step counts
    {3'b000, 32'd6}   // R5
  };

  task automatic step(input logic a, input logic b, input logic z);
    @(negedge clk);
    inc_in = a; dec_in = b; idx_in = z;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1;
    check("R1 count", count, 32'd5);
    check("R1 tc", {31'd0, tc_pulse}, 32'd0);
    @(negedge clk) rst = 1'b0;

    foreach (VEC[i]) begin
      step(VEC[i][34], VEC[i][33], VEC[i][32]);
      check("R2-table", count, VEC[i][31:0]);
    end

    // R6: the rising edge of inc_in creates the matching level pair 10
    reload_state = 2'b10;
    step(1, 0, 1);
    check("R6 priority", count, 32'd5);
    step(0, 0, 0);
    reload_state = 2'b00;

    // R8 / R7: count down through zero into negatives
    preload = 32'd2;
    step(0, 0, 1);
    step(0, 0, 0);
    step(0, 1, 0); step(0, 0, 0);
    check("R3 down", count, 32'd1);
    step(0, 1, 0);
    check("R8 zero", count, 32'd0);
    check("R8 tc start", {31'd0, tc_pulse}, 32'd1);
    n = 1;
    for (int k = 0; k < 40; k++) begin
      step(0, 0, 0);
      if (tc_pulse) n++; else break;
    end
    check("R8 tc length", n, TCL);
    for (int k = 0; k < 20; k++) begin
      step(0, 1, 0); step(0, 0, 0);
    end
    check("R7 negative", count, 32'hFFFF_FFEC);

    // R8: reload to zero raises no pulse
    preload = 32'd0;
    step(0, 0, 1);
    step(0, 0, 0);
    check("R8 reload zero value", count, 32'd0);
    check("R8 reload no tc", {31'd0, tc_pulse}, 32'd0);
    step(0, 1, 0);
    check("R7 wrap down", count, 32'hFFFF_FFFF);
    step(0, 0, 0);
    step(1, 0, 0);
    check("R7 wrap up", count, 32'd0);
    check("R8 tc from -1", {31'd0, tc_pulse}, 32'd1);
    step(0, 0, 0);

    // R9: edge mode
    edge_reload = 1'b1;
    preload = 32'd50;
    step(1, 0, 0); step(0, 0, 0);
    step(1, 0, 1);
    check("R9 edge reload", count, 32'd50);
    step(0, 0, 1);
    step(1, 0, 1);
    check("R9 held index", count, 32'd51);
    step(0, 0, 1);
    check("R9 held idle", count, 32'd51);
    step(0, 0, 0);
    step(0, 1, 1);
    check("R9 reload ignores levels", count, 32'd50);
    step(0, 0, 0);

    // R1: reset restores the preload
    preload = 32'd77;
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    check("R1 reset again", count, 32'd77);
    @(negedge clk) rst = 1'b0;
    finish_run();
  end
endmodule